// File: doc/BRIEF.md
# MESI Snooping Line Coherence Controller

This block keeps a small group of private write-back caches coherent on one shared snooping bus. Every cache in the group owns one line controller. The controller holds a four-state coherence tag for that line: Modified, Exclusive-clean, Shared or Invalid. It also holds the line address. Each cycle, at most one processor request comes in, and it names the requesting cache, read or write, and the address. The requester's controller works out whether the request hits. It then either completes silently or places a bus read or a bus read-exclusive on the bus. The other controllers snoop that command against their own line address and react in the same cycle.

A bus read qualifies itself through a wired shared line. Every other cache that holds a valid copy asserts it, and the requester samples it in the same cycle as the read. An unshared read miss fills the line as Exclusive-clean, so a later write upgrades the line to Modified without any bus cycle. The block also names the single cache that supplies data for a bus command. A dirty holder always supplies, and it also writes the data back to memory. Otherwise the lowest-numbered clean holder supplies and the others stay quiet. When no cache supplies, memory does. A miss that displaces a Modified line at a different address raises a victim write-back with the old address. Data arrays, memory and bus arbitration are outside the block.

Top module: `mesi_snoop_cluster`

## Requirements
- R1: While reset is asserted and after it is released, every line reads Invalid. Line-state codes are Invalid 4'b0001, Shared 4'b0010, Exclusive 4'b0100 and Modified 4'b1000, cache i in line_state[4i+3:4i]. With no request, bus_cmd is 0, supplier is 0 and evict is 0.
- R2: Every line's state code is exactly one of the four one-hot codes at all times.
- R3: A read that misses puts bus_cmd=1 (bus read) with bus_addr equal to the request address in the same cycle. The requester's line becomes Exclusive if bus_shared was low in that cycle, and Shared otherwise.
- R4: A read that hits (the line is valid and its address matches) sets req_hit, leaves bus_cmd=0, and changes no line state.
- R5: A write that hits an Exclusive line moves it to Modified with bus_cmd=0.
- R6: A write that misses, or that hits a Shared line, drives bus_cmd=2 (read-exclusive) with bus_addr. The requester's line becomes Modified at the request address.
- R7: A write that hits a Modified line keeps it Modified with bus_cmd=0.
- R8: On a bus read, every other cache holding a valid line at that address asserts bus_shared, and its line becomes Shared.
- R9: On a read-exclusive, every other cache holding a valid line at that address moves it to Invalid, and bus_shared stays low.
- R10: During a bus command, supplier is one-hot or zero. It marks the other cache that holds the address in Modified if there is one, with supply_dirty=1. Otherwise it marks the lowest-numbered other cache that holds the address clean, with supply_dirty=0. If no other cache holds the address, supplier is zero.
- R11: A miss by a cache whose line is Modified at a different address raises evict in the same cycle, with evict_addr set to the displaced address.
- R12: A cache whose line does not match the bus address, or is Invalid, keeps its state.
- R13: No line that is Exclusive or Modified ever shares its address with a valid line in another cache.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | A processor request is present this cycle |
| req_cpu | input | ID_W | Index of the requesting cache |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ADDR_W | Line address of the request |
| req_hit | output | 1 | The request hits in the requester's line |
| bus_cmd | output | 2 | 0 idle, 1 bus read, 2 bus read-exclusive |
| bus_addr | output | ADDR_W | Address of the bus command, 0 when idle |
| bus_shared | output | 1 | Wired shared line, valid during a bus read |
| supplier | output | NCACHE | One-hot cache that provides the line data |
| supply_dirty | output | 1 | The supplier holds the line Modified and flushes it to memory |
| evict | output | 1 | Victim write-back of a displaced Modified line |
| evict_addr | output | ADDR_W | Address of the displaced line |
| line_state | output | 4*NCACHE | One-hot state of each cache's line |

## Verification
The bench runs a three-cache group through a read, read, write, read, read script on one address. It then runs a long pseudo-random sweep over three addresses that compete for the three lines, and a reference model computed in the bench predicts every output and state. The sweep targets several corner cases, each with its own failure.
- Shared-line qualification of a read miss: a faulty design would fill Exclusive while another copy exists, or fill Shared when the line is alone.
- The silent Exclusive-to-Modified upgrade versus the bus upgrade from Shared: a faulty design would waste a bus cycle, or leave stale copies valid.
- Supplier choice when a dirty holder and clean holders coexist, or several clean holders exist: a faulty design would pick two suppliers or a non-lowest one.
- Victim write-back when a Modified line is displaced: a faulty design would lose dirty data silently.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

  localparam int unsigned ST_W = 4;

  // One-hot line coherence state
  typedef enum logic [ST_W-1:0] {
    LS_INV = 4'b0001,
    LS_SHD = 4'b0010,
    LS_EXC = 4'b0100,
    LS_MOD = 4'b1000
  } line_st_e;

  // Command placed on the snooping bus
  typedef enum logic [1:0] {
    BC_IDLE  = 2'd0,
    BC_READ  = 2'd1,
    BC_READX = 2'd2
  } bus_cmd_e;

endpackage

// File: rtl/mesi_rst_sync.sv
module mesi_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_mine,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  bus_cmd_e          bus_cmd,
  input  logic              bus_shared,
  output logic              snoop_match,
  output logic              held_dirty,
  output logic              cpu_hit,
  output bus_cmd_e          cmd_out,
  output logic              victim_wb,
  output logic [ADDR_W-1:0] tag_out,
  output line_st_e          state_out
);

  line_st_e          st_q, st_d;
  logic              st_en;
  logic [ADDR_W-1:0] tag_q;
  logic              tag_en;

  // Address compare against the held line, shared by hit and snoop paths
  assign snoop_match = (st_q != LS_INV) && (tag_q == req_addr);
  assign held_dirty  = (st_q == LS_MOD);
  assign cpu_hit     = req_valid && req_mine && snoop_match;

  // Command this controller places on the bus as requester
  always_comb begin
    cmd_out   = BC_IDLE;
    victim_wb = 1'b0;
    if (req_valid && req_mine) begin
      if (!snoop_match) begin
        cmd_out   = req_write ? BC_READX : BC_READ;
        victim_wb = held_dirty;
      end else if (req_write && (st_q == LS_SHD)) begin
        cmd_out = BC_READX;
      end
    end
  end

  // Next state: requester fill/upgrade or snooper downgrade
  always_comb begin
    st_d   = st_q;
    tag_en = 1'b0;
    if (req_valid) begin
      if (req_mine) begin
        if (req_write) begin
          st_d = LS_MOD;
        end else if (!snoop_match) begin
          st_d = bus_shared ? LS_SHD : LS_EXC;
        end
        tag_en = !snoop_match;
      end else if (snoop_match) begin
        unique case (bus_cmd)
          BC_READ:  st_d = LS_SHD;
          BC_READX: st_d = LS_INV;
          default:  st_d = st_q;
        endcase
      end
    end
  end

  assign st_en = (st_d != st_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= LS_INV;
    end else if (st_en) begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q <= '0;
    end else if (tag_en) begin
      tag_q <= req_addr;
    end
  end

  assign tag_out   = tag_q;
  assign state_out = st_q;

endmodule

// File: rtl/mesi_supply_pick.sv
module mesi_supply_pick #(
  parameter int unsigned NCACHE = 4
) (
  input  logic              bus_active,
  input  logic [NCACHE-1:0] dirty_cand,
  input  logic [NCACHE-1:0] clean_cand,
  output logic [NCACHE-1:0] pick,
  output logic              pick_dirty
);

  function automatic logic [NCACHE-1:0] lowest_set(input logic [NCACHE-1:0] v);
    logic [NCACHE-1:0] r;
    r = '0;
    for (int i = NCACHE - 1; i >= 0; i--) begin
      if (v[i]) begin
        r    = '0;
        r[i] = 1'b1;
      end
    end
    return r;
  endfunction

  always_comb begin
    pick       = '0;
    pick_dirty = 1'b0;
    if (bus_active) begin
      if (|dirty_cand) begin
        pick       = lowest_set(dirty_cand);
        pick_dirty = 1'b1;
      end else begin
        pick = lowest_set(clean_cand);
      end
    end
  end

endmodule

// File: rtl/mesi_snoop_cluster.sv
module mesi_snoop_cluster
  import mesi_pkg::*;
#(
  parameter  int unsigned NCACHE = 4,
  parameter  int unsigned ADDR_W = 8,
  localparam int unsigned ID_W   = (NCACHE > 1) ? $clog2(NCACHE) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [ID_W-1:0]        req_cpu,
  input  logic                   req_write,
  input  logic [ADDR_W-1:0]      req_addr,
  output logic                   req_hit,
  output logic [1:0]             bus_cmd,
  output logic [ADDR_W-1:0]      bus_addr,
  output logic                   bus_shared,
  output logic [NCACHE-1:0]      supplier,
  output logic                   supply_dirty,
  output logic                   evict,
  output logic [ADDR_W-1:0]      evict_addr,
  output logic [NCACHE*ST_W-1:0] line_state
);

  logic                     core_rst_n;
  logic [NCACHE-1:0]        req_sel;
  logic [NCACHE-1:0]        match_v;
  logic [NCACHE-1:0]        dirty_v;
  logic [NCACHE-1:0]        hit_v;
  logic [NCACHE-1:0]        wb_v;
  bus_cmd_e                 cmd_v [NCACHE];
  logic [ADDR_W-1:0]        tag_v [NCACHE];
  line_st_e                 st_v  [NCACHE];
  logic [NCACHE*ADDR_W-1:0] tag_flat;
  logic [1:0]               cmd_or;
  bus_cmd_e                 cmd_bus;
  logic [ADDR_W-1:0]        evict_addr_or;
  logic                     bus_active;
  logic [NCACHE-1:0]        others_v;

  mesi_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_n_sync (core_rst_n)
  );

  for (genvar gi = 0; gi < NCACHE; gi++) begin : g_line
    assign req_sel[gi] = req_valid && (req_cpu == ID_W'(gi));

    mesi_line_ctrl #(.ADDR_W(ADDR_W)) i_line (
      .clk         (clk),
      .rst_n       (core_rst_n),
      .req_valid   (req_valid),
      .req_mine    (req_sel[gi]),
      .req_write   (req_write),
      .req_addr    (req_addr),
      .bus_cmd     (cmd_bus),
      .bus_shared  (bus_shared),
      .snoop_match (match_v[gi]),
      .held_dirty  (dirty_v[gi]),
      .cpu_hit     (hit_v[gi]),
      .cmd_out     (cmd_v[gi]),
      .victim_wb   (wb_v[gi]),
      .tag_out     (tag_v[gi]),
      .state_out   (st_v[gi])
    );

    assign line_state[gi*ST_W +: ST_W]   = st_v[gi];
    assign tag_flat[gi*ADDR_W +: ADDR_W] = tag_v[gi];
  end

  // Only the requester drives a command or a victim; combine by OR
  always_comb begin
    cmd_or        = '0;
    evict_addr_or = '0;
    for (int i = 0; i < NCACHE; i++) begin
      cmd_or = cmd_or | cmd_v[i];
      if (wb_v[i]) begin
        evict_addr_or = evict_addr_or | tag_v[i];
      end
    end
  end

  assign cmd_bus    = bus_cmd_e'(cmd_or);
  assign bus_active = (cmd_bus != BC_IDLE);
  assign others_v   = match_v & ~req_sel;

  // Wired shared line: any other valid holder during a bus read
  assign bus_shared = (cmd_bus == BC_READ) && (|others_v);

  mesi_supply_pick #(.NCACHE(NCACHE)) i_supply (
    .bus_active (bus_active),
    .dirty_cand (others_v & dirty_v),
    .clean_cand (others_v & ~dirty_v),
    .pick       (supplier),
    .pick_dirty (supply_dirty)
  );

  assign req_hit    = |hit_v;
  assign bus_cmd    = cmd_or;
  assign bus_addr   = bus_active ? req_addr : '0;
  assign evict      = |wb_v;
  assign evict_addr = evict_addr_or;

endmodule

// File: rtl/mesi_cluster_chk.sv
module mesi_cluster_chk #(
  parameter  int unsigned NCACHE = 4,
  parameter  int unsigned ADDR_W = 8,
  localparam int unsigned ID_W   = (NCACHE > 1) ? $clog2(NCACHE) : 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic [ID_W-1:0]        req_cpu,
  input logic                   req_write,
  input logic                   req_hit,
  input logic [1:0]             bus_cmd,
  input logic                   bus_shared,
  input logic [NCACHE-1:0]      supplier,
  input logic                   evict,
  input logic [NCACHE*4-1:0]    line_state,
  input logic [NCACHE*ADDR_W-1:0] tag_flat
);

  for (genvar gi = 0; gi < NCACHE; gi++) begin : g_one
    p_state_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(line_state[gi*4 +: 4]));

    for (genvar gj = 0; gj < NCACHE; gj++) begin : g_pair
      if (gi != gj) begin : g_diff
        p_single_owner_r13: assert property (@(posedge clk) disable iff (!rst_n)
          !((line_state[gi*4 +: 4] == 4'b0100 || line_state[gi*4 +: 4] == 4'b1000) &&
            (line_state[gj*4 +: 4] != 4'b0001) &&
            (tag_flat[gi*ADDR_W +: ADDR_W] == tag_flat[gj*ADDR_W +: ADDR_W])));
      end
    end
  end

  p_supplier_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(supplier));

  p_supply_needs_bus_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|supplier) |-> (bus_cmd != 2'd0));

  p_readmiss_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_cpu < NCACHE && !req_write && !req_hit) |-> (bus_cmd == 2'd1));

  p_readhit_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_hit) |=> $stable(line_state));

  p_write_owner_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_cpu < NCACHE) |=>
      (line_state[$past(req_cpu)*4 +: 4] == 4'b1000));

  p_rdx_not_shared_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd == 2'd2) |-> !bus_shared);

  p_evict_on_miss_r11: assert property (@(posedge clk) disable iff (!rst_n)
    evict |-> (bus_cmd != 2'd0 && !req_hit));

endmodule

bind mesi_snoop_cluster mesi_cluster_chk #(
  .NCACHE (NCACHE),
  .ADDR_W (ADDR_W)
) i_chk (
  .clk        (clk),
  .rst_n      (core_rst_n),
  .req_valid  (req_valid),
  .req_cpu    (req_cpu),
  .req_write  (req_write),
  .req_hit    (req_hit),
  .bus_cmd    (bus_cmd),
  .bus_shared (bus_shared),
  .supplier   (supplier),
  .evict      (evict),
  .line_state (line_state),
  .tag_flat   (tag_flat)
);

// File: tb/test_mesi_snoop_cluster.sv
module test_mesi_snoop_cluster;

  localparam int NC         = 3;
  localparam int AW         = 8;
  localparam int IW         = 2;
  localparam int CLK_PERIOD = 10;

  localparam logic [3:0] S_I = 4'b0001;
  localparam logic [3:0] S_S = 4'b0010;
  localparam logic [3:0] S_E = 4'b0100;
  localparam logic [3:0] S_M = 4'b1000;

  logic            clk;
  logic            rst_n;
  logic            req_valid;
  logic [IW-1:0]   req_cpu;
  logic            req_write;
  logic [AW-1:0]   req_addr;
  logic            req_hit;
  logic [1:0]      bus_cmd;
  logic [AW-1:0]   bus_addr;
  logic            bus_shared;
  logic [NC-1:0]   supplier;
  logic            supply_dirty;
  logic            evict;
  logic [AW-1:0]   evict_addr;
  logic [NC*4-1:0] line_state;

  int checks;
  int errors;

  logic [3:0]    mst  [NC];
  logic [AW-1:0] mtag [NC];

  mesi_snoop_cluster #(.NCACHE(NC), .ADDR_W(AW)) i_mesi_snoop_cluster (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_cpu      (req_cpu),
    .req_write    (req_write),
    .req_addr     (req_addr),
    .req_hit      (req_hit),
    .bus_cmd      (bus_cmd),
    .bus_addr     (bus_addr),
    .bus_shared   (bus_shared),
    .supplier     (supplier),
    .supply_dirty (supply_dirty),
    .evict        (evict),
    .evict_addr   (evict_addr),
    .line_state   (line_state)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] st_of(input int j);
    return line_state[j*4 +: 4];
  endfunction

  // One request, predicted from the requirements by a bench-side model
  task automatic do_op(input int c, input bit w, input logic [AW-1:0] a);
    logic          hit;
    logic [NC-1:0] m;
    logic [1:0]    ecmd;
    logic          esh;
    logic [NC-1:0] esup;
    logic          edirty;
    logic          eev;
    logic [AW-1:0] eev_addr;
    string         tg;
    hit = (mst[c] != S_I) && (mtag[c] == a);
    for (int j = 0; j < NC; j++) m[j] = (j != c) && (mst[j] != S_I) && (mtag[j] == a);
    if (!w) ecmd = hit ? 2'd0 : 2'd1;
    else    ecmd = (!hit || mst[c] == S_S) ? 2'd2 : 2'd0;
    if (!w)                          tg = hit ? "R4" : "R3";
    else if (!hit || mst[c] == S_S)  tg = "R6";
    else if (mst[c] == S_E)          tg = "R5";
    else                             tg = "R7";
    esh    = (ecmd == 2'd1) && (|m);
    esup   = '0;
    edirty = 1'b0;
    if (ecmd != 2'd0) begin
      for (int j = 0; j < NC; j++) begin
        if (m[j] && mst[j] == S_M) begin
          esup[j] = 1'b1;
          edirty  = 1'b1;
        end
      end
      if (!edirty) begin
        for (int j = NC - 1; j >= 0; j--) if (m[j]) esup = NC'(1) << j;
      end
    end
    eev      = !hit && (mst[c] == S_M);
    eev_addr = mtag[c];

    @(negedge clk);
    req_valid = 1'b1;
    req_cpu   = IW'(c);
    req_write = w;
    req_addr  = a;
    #1;
    chk(tg, "req_hit", 32'(req_hit), 32'(hit));
    chk(tg, "bus_cmd", 32'(bus_cmd), 32'(ecmd));
    if (ecmd != 2'd0) chk(tg, "bus_addr", 32'(bus_addr), 32'(a));
    chk("R8", "bus_shared", 32'(bus_shared), 32'(esh));
    chk("R10", "supplier", 32'(supplier), 32'(esup));
    chk("R10", "supply_dirty", 32'(supply_dirty), 32'(edirty));
    chk("R11", "evict", 32'(evict), 32'(eev));
    if (eev) chk("R11", "evict_addr", 32'(evict_addr), 32'(eev_addr));

    // Model update
    for (int j = 0; j < NC; j++) begin
      if (m[j]) begin
        if (ecmd == 2'd1) mst[j] = S_S;
        else if (ecmd == 2'd2) mst[j] = S_I;
      end
    end
    if (w) begin
      mst[c]  = S_M;
      mtag[c] = a;
    end else if (!hit) begin
      mst[c]  = esh ? S_S : S_E;
      mtag[c] = a;
    end

    @(posedge clk);
    #1;
    req_valid = 1'b0;
    for (int j = 0; j < NC; j++) begin
      string sj;
      if (j == c)                sj = tg;
      else if (m[j] && ecmd == 2'd1) sj = "R8";
      else if (m[j] && ecmd == 2'd2) sj = "R9";
      else                       sj = "R12";
      chk(sj, $sformatf("state cache%0d", j), 32'(st_of(j)), 32'(mst[j]));
      chk("R2", $sformatf("onehot cache%0d", j), 32'($countones(st_of(j))), 32'd1);
    end
  endtask

  task automatic chk_states(input string req, input logic [3:0] s0,
                            input logic [3:0] s1, input logic [3:0] s2);
    chk(req, "script cache0", 32'(st_of(0)), 32'(s0));
    chk(req, "script cache1", 32'(st_of(1)), 32'(s1));
    chk(req, "script cache2", 32'(st_of(2)), 32'(s2));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired before the run completed");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    checks    = 0;
    errors    = 0;
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_cpu   = '0;
    req_write = 1'b0;
    req_addr  = '0;
    for (int j = 0; j < NC; j++) begin
      mst[j]  = S_I;
      mtag[j] = '0;
    end

    // R1: reset state, while asserted and after release
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "states in reset", 32'(line_state), 32'({NC{S_I}}));
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "states after reset", 32'(line_state), 32'({NC{S_I}}));
    chk("R1", "bus idle", 32'(bus_cmd), 32'd0);
    chk("R1", "no supplier", 32'(supplier), 32'd0);
    chk("R1", "no evict", 32'(evict), 32'd0);

    // Scripted sharing sequence on one address
    do_op(0, 1'b0, 8'h40); chk_states("R3", S_E, S_I, S_I);
    do_op(2, 1'b0, 8'h40); chk_states("R8", S_S, S_I, S_S);
    do_op(2, 1'b1, 8'h40); chk_states("R9", S_I, S_I, S_M);
    do_op(0, 1'b0, 8'h40); chk_states("R10", S_S, S_I, S_S);
    do_op(1, 1'b0, 8'h40); chk_states("R8", S_S, S_S, S_S);

    // Write upgrade from Shared with two clean suppliers, lowest wins
    do_op(2, 1'b1, 8'h40); chk_states("R6", S_I, S_I, S_M);
    do_op(2, 1'b1, 8'h40); chk_states("R7", S_I, S_I, S_M);
    // Silent Exclusive upgrade, then eviction of the dirty line
    do_op(1, 1'b0, 8'h80); chk_states("R3", S_I, S_E, S_M);
    do_op(1, 1'b1, 8'h80); chk_states("R5", S_I, S_M, S_M);
    do_op(1, 1'b0, 8'h90); chk_states("R11", S_I, S_E, S_M);
    do_op(1, 1'b0, 8'h90); chk_states("R4", S_I, S_E, S_M);

    // Pseudo-random sweep over three competing addresses
    lf = 16'hACE1;
    for (int k = 0; k < 600; k++) begin
      int            c;
      bit            w;
      logic [AW-1:0] a;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      c  = int'(lf[7:0]) % NC;
      w  = lf[9] & lf[3];
      a  = AW'(8'h10 * (1 + (int'(lf[15:12]) % 3)));
      do_op(c, w, a);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule